// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator Counter

This block is an 8-bit accumulator for pulses on a single external input. It has two modes. In event mode the counter steps once for each transition of the input in the chosen direction. In gated mode the counter steps on a free-running tick, one for every 64 system clocks, and only while the input sits at its active level. One polarity bit serves both modes. In event mode it chooses the rising or falling transition. In gated mode it chooses whether the active level is high or low. The external input passes through a two-flop synchronizer. Both modes then share one small level tracker. That tracker records whether the input was active in the last cycle, and from this it reports when the input becomes active (the "open" transition) and when it stops being active (the "close" transition).

Software reaches the block through a simple register bus with a 2-bit address, a write strobe and a combinational read path. The count can be read or written at any time. The overflow flag and the input flag are cleared by writing a 1 to them. Each flag has its own interrupt enable and its own request output.

Top module: `pulse_accum`

The level tracker has two states: `LVL_IDLE`, where the input is not at its active level, and `LVL_ACTIVE`, where it is. It takes the transition T_OPEN from `LVL_IDLE` to `LVL_ACTIVE` in the cycle the synchronized input becomes active. It takes the transition T_CLOSE back to `LVL_IDLE` in the cycle the synchronized input stops being active. Otherwise it stays in its current state.

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are low.
- R2: In event mode with enable set, the count steps by exactly one on each open transition: a rising pin when polarity = 0, a falling pin when polarity = 1. The new count is visible after the third rising clock edge that follows the pin change.
- R3: While the enable bit is clear, the count keeps its value whatever the pin does.
- R4: In gated mode with enable set, the count steps once for each 64-cycle prescaler tick that occurs while the synchronized pin is active (high for polarity 0, low for polarity 1). It holds while the pin is inactive. The prescaler runs freely from reset and is never restarted by the pin.
- R5: A step taken at count 0xFF wraps the count to 0x00 and sets the overflow flag. In gated mode, a continuously active pin reaches this after 16384 clocks.
- R6: The input flag sets on an open transition in event mode and on a close transition in gated mode. Writing 1 to a flag bit in the status register clears that flag only. Writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R7: irq_ovf is high exactly when the overflow flag and its enable are both 1. irq_edge is high exactly when the input flag and its enable are both 1.
- R8: When a count write and a count step happen in the same cycle, the written value is stored, and the lost step does not set the overflow flag.
- R9: Pin pulses whose high and low phases each last one clock are all counted.
- R10: Register map. Address 0 is control: bit0 enable, bit1 gated mode, bit2 polarity, bit3 overflow interrupt enable, bit4 input interrupt enable; bits 7:5 read 0. Address 1 is status: bit0 overflow flag, bit1 input flag. Address 2 is the count. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pa_in | input | 1 | External pulse input, asynchronous |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Input-transition interrupt request |

## Verification
The hardest case to produce is a software write to the count landing in exactly the cycle that an increment takes effect. The bench reaches it in event mode. It changes the pin, lets exactly two clock edges pass through the synchronizer, and then issues the write so that it meets the increment on the third edge. The gated-mode overflow needs more than 16384 clocks with the pin held active. The bench runs through it while its reference model, which tracks the free-running prescaler phase, compares the read data and both interrupt outputs on every clock.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd2;

    localparam int STAT_OVF  = 0;
    localparam int STAT_EDGE = 1;

    // control register, enable in bit 0 upward
    typedef struct packed {
        logic ie_edge;
        logic ie_ovf;
        logic pol;
        logic gated;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic {
        LVL_IDLE   = 1'b0,
        LVL_ACTIVE = 1'b1
    } lvl_state_e;

endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
    parameter int DIV_BITS = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [DIV_BITS-1:0] div_q;

    // free running: nothing but reset ever restarts it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign tick = &div_q;
endmodule

// File: rtl/pacc_level_fsm.sv
module pacc_level_fsm
    import pacc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_sync,
    input  logic pol,
    output logic active_now,
    output logic open_pulse,
    output logic close_pulse
);
    lvl_state_e state_q, state_d;

    assign active_now = lvl_sync ^ pol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        open_pulse  = 1'b0;
        close_pulse = 1'b0;
        unique case (state_q)
            LVL_IDLE: begin
                if (active_now) begin       // T_OPEN
                    state_d    = LVL_ACTIVE;
                    open_pulse = 1'b1;
                end
            end
            LVL_ACTIVE: begin
                if (!active_now) begin      // T_CLOSE
                    state_d     = LVL_IDLE;
                    close_pulse = 1'b1;
                end
            end
            default: state_d = LVL_IDLE;
        endcase
    end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pacc_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int PRESCALE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pa_in,
    output logic              irq_ovf,
    output logic              irq_edge
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] cnt_q;
    logic              flag_ovf_q, flag_edge_q;

    logic pin_sync, pre_tick;
    logic active_now, open_pulse, close_pulse;
    logic wr_ctrl, wr_stat, wr_cnt;
    logic step, wrap, edge_evt;

    pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst_n(rst_n), .d(pa_in), .q(pin_sync)
    );

    pacc_prescale #(.DIV_BITS(PRESCALE_BITS)) u_prescale (
        .clk (clk), .rst_n(rst_n), .tick(pre_tick)
    );

    pacc_level_fsm u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_sync   (pin_sync),
        .pol        (ctrl_q.pol),
        .active_now (active_now),
        .open_pulse (open_pulse),
        .close_pulse(close_pulse)
    );

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
    assign wr_cnt  = bus_wr && (bus_addr == ADDR_COUNT);

    assign step     = ctrl_q.en && (ctrl_q.gated ? (pre_tick && active_now) : open_pulse);
    assign wrap     = step && !wr_cnt && (cnt_q == '1);
    assign edge_evt = ctrl_q.gated ? close_pulse : open_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    // software write takes priority over a step in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= bus_wdata;
        else if (step)   cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_ovf_q  <= 1'b0;
            flag_edge_q <= 1'b0;
        end else begin
            flag_ovf_q  <= wrap     | (flag_ovf_q  & ~(wr_stat & bus_wdata[STAT_OVF]));
            flag_edge_q <= edge_evt | (flag_edge_q & ~(wr_stat & bus_wdata[STAT_EDGE]));
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            ADDR_STAT:  bus_rdata = DATA_W'({flag_edge_q, flag_ovf_q});
            ADDR_COUNT: bus_rdata = cnt_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_ovf  = flag_ovf_q  & ctrl_q.ie_ovf;
    assign irq_edge = flag_edge_q & ctrl_q.ie_edge;
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker
    import pacc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] cnt,
    input logic              en,
    input logic              gated,
    input logic              tick,
    input logic              ovf_flag
);
    logic cnt_written;
    assign cnt_written = bus_wr && (bus_addr == ADDR_COUNT);

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_written) |-> cnt == $past(bus_wdata)); // R8

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en) && !$past(cnt_written)) |-> cnt == $past(cnt)); // R3

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_written) && cnt != $past(cnt)) |-> cnt == DATA_W'($past(cnt) + 1'b1)); // R2

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_written) && $past(cnt) == '1 && cnt == '0) |-> ovf_flag); // R5

    AST_GATED_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gated) && !$past(cnt_written) && cnt != $past(cnt)) |-> $past(tick)); // R4
endmodule

bind pulse_accum pacc_checker u_pacc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cnt      (cnt_q),
    .en       (ctrl_q.en),
    .gated    (ctrl_q.gated),
    .tick     (pre_tick),
    .ovf_flag (flag_ovf_q)
);

// File: tb/pulse_accum_bench.sv
module pulse_accum_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       pa_in = 1'b0;
    logic       irq_ovf, irq_edge;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    pulse_accum u_pulse_accum (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pa_in(pa_in),
        .irq_ovf(irq_ovf), .irq_edge(irq_edge)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_pipe[$] = '{0, 0};   // synchronizer history, oldest first
    int m_act_prev = 0, m_phase = 0, m_cnt = 0;
    int m_en = 0, m_gated = 0, m_pol = 0, m_ie_o = 0, m_ie_e = 0;
    int m_fo = 0, m_fe = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pipe = '{0, 0}; m_act_prev = 0; m_phase = 0; m_cnt = 0;
            m_en = 0; m_gated = 0; m_pol = 0; m_ie_o = 0; m_ie_e = 0;
            m_fo = 0; m_fe = 0;
        end else begin
            int act, opened, closed, stepping, wr_c, wr_s, set_o, set_e;
            act      = (m_pipe[0] != m_pol) ? 1 : 0;
            opened   = act && !m_act_prev;
            closed   = !act && m_act_prev;
            stepping = m_en && (m_gated ? (m_phase == 63 && act) : opened);
            wr_c     = bus_wr && bus_addr == 2;
            wr_s     = bus_wr && bus_addr == 1;
            set_o    = stepping && !wr_c && m_cnt == 255;
            set_e    = m_gated ? closed : opened;
            m_fo = set_o || (m_fo && !(wr_s && bus_wdata[0]));
            m_fe = set_e || (m_fe && !(wr_s && bus_wdata[1]));
            if (wr_c) m_cnt = bus_wdata;
            else if (stepping) m_cnt = (m_cnt + 1) % 256;
            if (bus_wr && bus_addr == 0) begin
                m_en = bus_wdata[0]; m_gated = bus_wdata[1]; m_pol = bus_wdata[2];
                m_ie_o = bus_wdata[3]; m_ie_e = bus_wdata[4];
            end
            m_act_prev = act;
            m_phase = (m_phase + 1) % 64;
            void'(m_pipe.pop_front());
            m_pipe.push_back(int'(pa_in));
        end
    end

    function automatic int model_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_en + 2*m_gated + 4*m_pol + 8*m_ie_o + 16*m_ie_e;
            2'd1: return m_fo + 2*m_fe;
            2'd2: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input string what, input int act,
                             input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // one clock; compare against the model at the falling edge
    task automatic cyc();
        @(negedge clk);
        if (rst_n) begin
            chk("R10", "per-cycle rdata", bus_rdata, model_rd(bus_addr));
            chk("R7", "per-cycle irq_ovf", irq_ovf, m_fo && m_ie_o);
            chk("R7", "per-cycle irq_edge", irq_edge, m_fe && m_ie_e);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic pulses(input int n, input int hi, input int lo, input bit low_going);
        for (int i = 0; i < n; i++) begin
            pa_in = low_going ? 1'b0 : 1'b1;
            repeat (hi) cyc();
            pa_in = ~pa_in;
            repeat (lo) cyc();
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        int v, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();

        // R1: reset state
        rd(2'd0, v); chk("R1", "ctrl after reset", v, 0);
        rd(2'd1, v); chk("R1", "status after reset", v, 0);
        rd(2'd2, v); chk("R1", "count after reset", v, 0);
        chk("R1", "irq_ovf after reset", irq_ovf, 0);
        chk("R1", "irq_edge after reset", irq_edge, 0);

        // R10: map and unused bits
        wr(2'd0, 8'hFA);
        rd(2'd0, v); chk("R10", "ctrl readback", v, 8'h1A);
        rd(2'd3, v); chk("R10", "address 3", v, 0);

        // R2: event mode, rising, latency
        wr(2'd0, 8'h01); wr(2'd2, 8'h00); wr(2'd1, 8'h03);
        bus_addr = 2'd2;
        pa_in = 1'b1;
        cyc(); cyc();
        rd(2'd2, v); chk("R2", "count before third edge", v, 0);
        cyc();
        rd(2'd2, v); chk("R2", "count after third edge", v, 1);
        rd(2'd1, v); chk("R6", "input flag on counted edge", v, 2);
        pa_in = 1'b0; repeat (4) cyc();
        pulses(5, 3, 3, 0);
        rd(2'd2, v); chk("R2", "five rising pulses", v, 6);

        // R9: one-clock pulses
        pulses(10, 1, 1, 0);
        repeat (4) cyc();
        rd(2'd2, v); chk("R9", "one-clock pulses", v, 16);

        // R2: falling polarity
        pa_in = 1'b1; repeat (5) cyc();
        wr(2'd0, 8'h05);
        repeat (3) cyc();
        rd(2'd2, v); chk("R2", "polarity switch no step", v, 17);
        pulses(4, 3, 3, 1);
        rd(2'd2, v); chk("R2", "four falling pulses", v, 21);

        // R3: disabled holds
        wr(2'd0, 8'h04);
        pulses(6, 3, 3, 1);
        rd(2'd2, v); chk("R3", "count held while disabled", v, 21);

        // R5/R6/R7: overflow and flags
        wr(2'd0, 8'h05); wr(2'd2, 8'hFE); wr(2'd1, 8'h03);
        pulses(2, 3, 3, 1);
        rd(2'd2, v); chk("R5", "wrap to zero", v, 0);
        rd(2'd1, v); chk("R5", "overflow and input flags", v, 3);
        chk("R7", "irq_ovf masked", irq_ovf, 0);
        wr(2'd0, 8'h0D);
        chk("R7", "irq_ovf enabled", irq_ovf, 1);
        wr(2'd1, 8'h01);
        rd(2'd1, v); chk("R6", "clear only overflow", v, 2);
        chk("R7", "irq_ovf after clear", irq_ovf, 0);
        wr(2'd0, 8'h15);
        chk("R7", "irq_edge enabled", irq_edge, 1);
        wr(2'd1, 8'h02);
        chk("R6", "irq_edge after clear", irq_edge, 0);

        // R8: write meets step
        wr(2'd0, 8'h05); wr(2'd2, 8'h30);
        pa_in = 1'b0;
        cyc(); cyc();
        wr(2'd2, 8'h80);
        rd(2'd2, v); chk("R8", "write wins over step", v, 8'h80);
        pa_in = 1'b1; repeat (4) cyc();
        rd(2'd2, v); chk("R8", "no later step", v, 8'h80);

        // R4: gated mode, active low
        wr(2'd0, 8'h07); wr(2'd2, 8'h00); wr(2'd1, 8'h03);
        pa_in = 1'b0;
        repeat (640) cyc();
        rd(2'd2, v); chk_range("R4", "gated ticks in 640 clocks", v, 9, 11);
        rd(2'd1, v); chk("R6", "no flag while gate open", v, 0);
        pa_in = 1'b1; repeat (5) cyc();
        rd(2'd2, c);
        repeat (300) cyc();
        rd(2'd2, v); chk("R4", "hold while inactive", v, c);
        rd(2'd1, v); chk("R6", "flag on gate close", v, 2);

        // R5: gated overflow
        wr(2'd2, 8'h00); wr(2'd1, 8'h03);
        pa_in = 1'b0;
        repeat (16584) cyc();
        rd(2'd1, v); chk("R5", "gated overflow flag", v & 1, 1);
        rd(2'd2, v); chk_range("R5", "gated count after wrap", v, 1, 5);

        report();
    end
endmodule